// File: doc/BRIEF.md
# Calendar Real-Time Clock with Coherent Read Snapshot

This block keeps wall-clock time and a calendar date. It advances on a 32.768 kHz tick enable that is sampled in the host clock domain. A prescaler turns the tick into one update per second. The update ripples through a chain of seconds, minutes, hours, weekday, day of month, month and two-digit year. Month lengths and leap Februaries are resolved in hardware.

Software sees seven byte-wide fields behind a small register port. Reading the seconds field returns the live value and, in the same cycle, freezes a copy of the six slower fields. Later reads of those fields return that frozen copy, so a multi-byte read is always consistent.

Field writes are staged and take effect on the next tick. A busy flag enforces a spacing of three ticks between writes. Two strobes let firmware trim the clock by plus or minus one second. An interrupt pulse marks each seconds update while it is enabled.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0, and busy, irq and rvalid are low.
- R2: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Address 7 reads 0. For a read (cs high, we low), rdata is valid with rvalid high exactly one clock later.
- R3: Every TICKS_PER_SEC ticks the seconds advance. Seconds 0–59 carry into minutes 0–59. Minutes carry into hours 0–23. Hours carry into the day, which steps the weekday 1–7 (7 wraps to 1) and the day of month.
- R4: The day of month wraps after 30 in April, June, September and November, and after 31 in the other months. February ends after 29 when year mod 4 is 0 and after 28 otherwise. Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R5: A read of address 0 returns the live seconds and captures all other fields. Reads of addresses 1–6 return the captured values until the next seconds read.
- R6: A write (cs and we high) is accepted only while busy is low. An accepted write raises busy, which stays high until the third tick after acceptance. A write attempted while busy is high changes nothing.
- R7: An accepted write is applied on the next tick. A seconds write also restarts the prescaler, so the next update comes TICKS_PER_SEC ticks after the applying tick.
- R8: When a write to a field other than seconds is applied on the same tick as a seconds update, the other fields advance normally and the written field takes the written value.
- R9: After an inc_sec pulse, the next update advances time by two seconds with full carries. After a dec_sec pulse, the next update leaves time unchanged. If both are pending, the update is normal.
- R10: irq pulses for one clock after every seconds update, including corrected ones, when irq_en is high at that update, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 32.768 kHz tick enable, one host clock wide |
| cs | input | 1 | Register access strobe |
| we | input | 1 | Write when high, read when low |
| addr | input | 3 | Field address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one clock after the read |
| busy | output | 1 | New writes refused while high |
| inc_sec | input | 1 | Add one second at the next update |
| dec_sec | input | 1 | Drop one second at the next update |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-clock pulse per seconds update when enabled |

## Verification
Two functions can meet on one tick: applying a staged field write and a seconds update whose carry reaches that same field.

The bench forces the meeting. It sets seconds to 59, waits until its own prescaler model is one tick short of rollover with busy clear, writes the hours field, and then issues that single tick. It then reads the whole time and expects the minutes to have carried, the seconds to have wrapped, and the hours to hold exactly the written value.

Random field writes, corrections and enable changes are then compared against a tick-level model kept in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_W = 8;
  localparam int ADDR_W  = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] mday;
    logic [FIELD_W-1:0] wday;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] minute;
    logic [FIELD_W-1:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{year: 8'd0, month: 8'd1, mday: 8'd1,
                                      wday: 8'd1, hour: 8'd0, minute: 8'd0,
                                      sec: 8'd0};

  // Last day of a month; leap when the two low year bits are zero.
  function automatic logic [FIELD_W-1:0] month_days(input logic [FIELD_W-1:0] mon,
                                                    input logic [FIELD_W-1:0] yr);
    case (mon)
      8'd2:                      month_days = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   month_days = 8'd30;
      default:                   month_days = 8'd31;
    endcase
  endfunction

  // One-second advance with the full carry chain.
  function automatic rtc_time_t next_second(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec < 8'd59) n.sec = t.sec + 8'd1;
    else begin
      n.sec = '0;
      if (t.minute < 8'd59) n.minute = t.minute + 8'd1;
      else begin
        n.minute = '0;
        if (t.hour < 8'd23) n.hour = t.hour + 8'd1;
        else begin
          n.hour = '0;
          n.wday = (t.wday >= 8'd7) ? 8'd1 : t.wday + 8'd1;
          if (t.mday < month_days(t.month, t.year)) n.mday = t.mday + 8'd1;
          else begin
            n.mday = 8'd1;
            if (t.month < 8'd12) n.month = t.month + 8'd1;
            else begin
              n.month = 8'd1;
              n.year  = (t.year >= 8'd99) ? 8'd0 : t.year + 8'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [FIELD_W-1:0] field_get(input rtc_time_t t,
                                                   input logic [ADDR_W-1:0] a);
    case (a)
      3'd0:    field_get = t.sec;
      3'd1:    field_get = t.minute;
      3'd2:    field_get = t.hour;
      3'd3:    field_get = t.wday;
      3'd4:    field_get = t.mday;
      3'd5:    field_get = t.month;
      3'd6:    field_get = t.year;
      default: field_get = '0;
    endcase
  endfunction

  function automatic rtc_time_t field_set(input rtc_time_t t,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [FIELD_W-1:0] v);
    rtc_time_t n;
    n = t;
    case (a)
      3'd0:    n.sec    = v;
      3'd1:    n.minute = v;
      3'd2:    n.hour   = v;
      3'd3:    n.wday   = v;
      3'd4:    n.mday   = v;
      3'd5:    n.month  = v;
      3'd6:    n.year   = v;
      default: n = t;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic sec_evt
);
  localparam int DW = $clog2(TICKS_PER_SEC);
  localparam logic [DW-1:0] LAST = DW'(TICKS_PER_SEC - 1);

  logic [DW-1:0] div_q;

  assign sec_evt = tick && !clr && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                      div_q <= '0;
    else if (tick) begin
      if (clr || div_q == LAST)      div_q <= '0;
      else                           div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_write_gate.sv
module rtc_write_gate #(
  parameter int SPACING = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_req,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       busy,
  output logic       apply,
  output logic [2:0] ap_addr,
  output logic [7:0] ap_data
);
  localparam int CW = $clog2(SPACING + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(SPACING);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          accept;

  assign busy   = (cnt_q != '0);
  assign accept = wr_req && !busy;
  assign apply  = tick && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ap_addr <= '0;
      ap_data <= '0;
    end else if (accept) begin
      cnt_q   <= CNT_INIT;
      pend_q  <= 1'b1;
      ap_addr <= wr_addr;
      ap_data <= wr_data;
    end else if (tick) begin
      pend_q <= 1'b0;
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_req,
  input  logic [2:0] rd_addr,
  input  rtc_time_t  live,
  output logic [7:0] rdata,
  output logic       rvalid
);
  rtc_time_t snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= RTC_RESET;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) begin
        if (rd_addr == 3'd0) begin
          snap_q <= live;
          rdata  <= live.sec;
        end else begin
          rdata  <= field_get(snap_q, rd_addr);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int WRITE_SPACING = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cs,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       busy,
  input  logic       inc_sec,
  input  logic       dec_sec,
  input  logic       irq_en,
  output logic       irq
);
  rtc_time_t  cur_q, one_ahead, two_ahead, adv_time, nxt_time;
  logic       sec_evt, apply, wr_sec;
  logic       inc_pend, dec_pend;
  logic [2:0] ap_addr;
  logic [7:0] ap_data;

  assign wr_sec = apply && (ap_addr == 3'd0);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(wr_sec), .sec_evt(sec_evt)
  );

  rtc_write_gate #(.SPACING(WRITE_SPACING)) u_wgate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_req(cs && we),
    .wr_addr(addr), .wr_data(wdata), .busy(busy), .apply(apply),
    .ap_addr(ap_addr), .ap_data(ap_data)
  );

  rtc_read_port u_rport (
    .clk(clk), .rst_n(rst_n), .rd_req(cs && !we), .rd_addr(addr),
    .live(cur_q), .rdata(rdata), .rvalid(rvalid)
  );

  always_comb begin
    one_ahead = next_second(cur_q);
    two_ahead = next_second(one_ahead);
    adv_time  = cur_q;
    if (sec_evt) begin
      case ({inc_pend, dec_pend})
        2'b10:   adv_time = two_ahead;
        2'b01:   adv_time = cur_q;
        default: adv_time = one_ahead;
      endcase
    end
    nxt_time = apply ? field_set(adv_time, ap_addr, ap_data) : adv_time;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= RTC_RESET;
      inc_pend <= 1'b0;
      dec_pend <= 1'b0;
      irq      <= 1'b0;
    end else begin
      cur_q    <= nxt_time;
      inc_pend <= (inc_pend && !sec_evt) || inc_sec;
      dec_pend <= (dec_pend && !sec_evt) || dec_sec;
      irq      <= sec_evt && irq_en;
    end
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick,
  input logic      cs,
  input logic      we,
  input logic      busy,
  input logic      rvalid,
  input logic      irq,
  input logic      irq_en,
  input logic      sec_evt,
  input rtc_time_t cur_time
);
  // R2
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we) |=> rvalid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> !rvalid);
  // R3
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_time));
  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && !busy) |=> busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
  // R10
  irq_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && irq_en) |=> irq);
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_evt || !irq_en) |=> !irq);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .busy(busy),
  .rvalid(rvalid), .irq(irq), .irq_en(irq_en), .sec_evt(sec_evt),
  .cur_time(cur_q)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
  localparam int TPS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cs = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rvalid, busy, irq;
  logic       inc_sec = 1'b0, dec_sec = 1'b0, irq_en = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model: 0 sec, 1 min, 2 hour, 3 wday, 4 mday, 5 month, 6 year
  int f[7];
  int snap[7];
  int mdiv = 0, mbusy = 0, mpaddr = 0, mpdata = 0;
  bit mpend = 0, minc = 0, mdec = 0, men = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS), .WRITE_SPACING(3)) i_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy),
    .inc_sec(inc_sec), .dec_sec(dec_sec), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bench_dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void bstep();
    int lim;
    f[0]++; if (f[0] < 60) return;
    f[0] = 0; f[1]++; if (f[1] < 60) return;
    f[1] = 0; f[2]++; if (f[2] < 24) return;
    f[2] = 0;
    f[3] = f[3] % 7 + 1;
    lim = bench_dim(f[5], f[6]);
    f[4]++; if (f[4] <= lim) return;
    f[4] = 1; f[5]++; if (f[5] <= 12) return;
    f[5] = 1; f[6] = (f[6] + 1) % 100;
  endfunction

  task automatic do_tick();
    bit evt;
    evt = 0;
    tick = 1'b1;
    @(posedge clk);
    if (mpend && mpaddr == 0) begin
      f[0] = mpdata; mdiv = 0;
    end else begin
      if (mdiv == TPS - 1) begin evt = 1; mdiv = 0; end
      else mdiv++;
      if (evt) begin
        if (minc && !mdec) begin bstep(); bstep(); end
        else if (!(mdec && !minc)) bstep();
        minc = 0; mdec = 0;
      end
      if (mpend && mpaddr < 7) f[mpaddr] = mpdata;
    end
    mpend = 0;
    if (mbusy > 0) mbusy--;
    @(negedge clk);
    tick = 1'b0;
    check("R10 irq", irq, int'(evt && men));
    check("R6 busy", busy, int'(mbusy != 0));
  endtask

  task automatic host_write(input int a, input int d);
    while (mbusy != 0) do_tick();
    check("R6 busy before write", busy, 0);
    cs = 1'b1; we = 1'b1; addr = a[2:0]; wdata = d[7:0];
    @(posedge clk);
    mpend = 1; mpaddr = a; mpdata = d; mbusy = 3;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    check("R6 busy after write", busy, 1);
  endtask

  task automatic host_read(input int a, input string tag);
    int exp;
    if (a == 0) exp = f[0];
    else if (a < 7) exp = snap[a];
    else exp = 0;
    cs = 1'b1; we = 1'b0; addr = a[2:0];
    @(posedge clk);
    if (a == 0) snap = f;
    @(negedge clk);
    cs = 1'b0;
    check({tag, " rvalid"}, rvalid, 1);
    check(tag, rdata, exp);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 7; a++) host_read(a, tag);
  endtask

  task automatic set_time(input int s, input int mi, input int h, input int wd,
                          input int md, input int mo, input int y);
    host_write(0, s); host_write(1, mi); host_write(2, h);
    host_write(3, wd); host_write(4, md); host_write(5, mo); host_write(6, y);
    while (mbusy != 0) do_tick();
  endtask

  task automatic to_update();
    while (mpend) do_tick();
    while (mdiv != TPS - 1) do_tick();
    do_tick();
  endtask

  task automatic pulse_corr(input bit i, input bit d);
    inc_sec = i; dec_sec = d;
    @(posedge clk);
    if (i) minc = 1;
    if (d) mdec = 1;
    @(negedge clk);
    inc_sec = 1'b0; dec_sec = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    f = '{0, 0, 0, 1, 1, 1, 0};
    snap = f;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 irq", irq, 0);
    check("R1 rvalid", rvalid, 0);
    read_all("R1 reset fields");
    // R2 unused address
    host_read(7, "R2 addr7");

    men = 1; irq_en = 1'b1;
    // R4 year end rollover, R3 carries
    set_time(59, 59, 23, 7, 31, 12, 99);
    to_update();
    read_all("R4 year wrap");
    check("R4 year end month", snap[5], 1);
    // R4 leap February
    set_time(59, 59, 23, 2, 28, 2, 4);
    to_update();
    read_all("R4 leap feb");
    check("R4 feb29", snap[4], 29);
    set_time(59, 59, 23, 2, 28, 2, 5);
    to_update();
    read_all("R4 common feb");
    check("R4 mar1", snap[5], 3);
    set_time(59, 59, 23, 3, 30, 4, 21);
    to_update();
    read_all("R4 april end");

    // R5 snapshot holds until next seconds read
    set_time(59, 5, 10, 1, 10, 6, 30);
    read_all("R5 pre");
    to_update();
    host_read(1, "R5 frozen minute");
    check("R5 frozen minute value", rdata, 5);
    host_read(0, "R5 live sec");
    host_read(1, "R5 fresh minute");
    check("R5 fresh minute value", rdata, 6);

    // R9 corrections
    set_time(59, 59, 23, 7, 31, 12, 99);
    pulse_corr(1, 0);
    to_update();
    read_all("R9 inc carry");
    check("R9 inc sec", snap[0], 1);
    pulse_corr(0, 1);
    to_update();
    read_all("R9 dec hold");
    pulse_corr(1, 1);
    to_update();
    read_all("R9 both");

    // R10 disabled interrupt
    men = 0; irq_en = 1'b0;
    to_update();
    men = 1; irq_en = 1'b1;

    // R6 write while busy ignored
    host_write(1, 10);
    cs = 1'b1; we = 1'b1; addr = 3'd1; wdata = 8'd33;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    do_tick(); do_tick(); do_tick();
    check("R6 busy cleared", busy, 0);
    read_all("R6 ignored write");

    // R7 seconds write restarts prescaler
    host_write(0, 30);
    do_tick();
    for (int k = 0; k < TPS - 1; k++) do_tick();
    host_read(0, "R7 before");
    check("R7 sec held", rdata, 30);
    do_tick();
    host_read(0, "R7 after");
    check("R7 sec stepped", rdata, 31);

    // R8 write applied on the update tick
    set_time(59, 10, 5, 3, 12, 7, 44);
    while (!(mdiv == TPS - 1 && mbusy == 0)) do_tick();
    host_write(2, 7);
    check("R8 no early tick", mdiv, TPS - 1);
    do_tick();
    read_all("R8 concurrent");
    check("R8 minute carried", snap[1], 11);
    check("R8 hour written", snap[2], 7);

    // R3 random mix
    for (int it = 0; it < 40; it++) begin
      int r, a, v, n;
      r = $urandom % 4;
      case (r)
        0: begin
          a = $urandom % 7;
          case (a)
            0, 1: v = $urandom % 60;
            2: v = $urandom % 24;
            3: v = 1 + $urandom % 7;
            4: v = 1 + $urandom % 28;
            5: v = 1 + $urandom % 12;
            default: v = $urandom % 100;
          endcase
          host_write(a, v);
        end
        1: pulse_corr(1'($urandom % 2), 1'($urandom % 2));
        2: begin men = 1'($urandom % 2); irq_en = men; end
        default: ;
      endcase
      n = $urandom % 150;
      for (int k = 0; k < n; k++) do_tick();
      read_all("R3 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule